// File: doc/BRIEF.md
# Column-Parity Protected Settings Register File

This block holds the thresholds and settings used by a protection datapath. A supervising host reads and writes it over a simple parallel bus with separate write and read strobes. The map holds `NUM_REGS` settings registers plus one check word. The host keeps the check word equal to the bitwise XOR of all settings registers, which is a parity per bit column. Every location, the check word included, can be read back, so the host can scan the whole map at regular intervals.

The block recomputes the column parity on every cycle and compares it with the stored check word. A host may update a setting and then the check word at any time during operation. A mismatch that lasts past a grace window of `GRACE` cycles after the last mapped write sets a sticky error flag, which shows that the host wrote corrupt or erratic data. The protection side never reads the raw registers. It sees a snapshot that is taken only while the map is consistent and no error is flagged. If the host stops or misbehaves, protection keeps running on the last settings that were self-consistent.

Top module: `cfg_parity_map`

## Requirements
- R1: After reset every settings register, the check word, the protection output `cfgOut` and `parityErr` are zero.
- R2: A write to address i (0 to NUM_REGS-1) stores `wrData` in settings register i, and a write to address NUM_REGS stores the check word. A read strobe captures the addressed word into `rdData` at the next clock edge. Settings register i appears at `cfgOut[i*DATA_W +: DATA_W]`.
- R3: Writes to addresses above NUM_REGS change no stored word, and reads of those addresses return zero.
- R4: The map counts as consistent exactly when the XOR of all settings registers equals the check word.
- R5: If the map stays inconsistent with no mapped write, `parityErr` rises at the (GRACE+1)-th clock edge after the last mapped write. A mapped write restarts this window. Writes to addresses above NUM_REGS do not restart it.
- R6: `parityErr` is sticky. It stays set until reset, even after the host makes the map consistent again.
- R7: `cfgOut` takes the register values one clock edge after the map becomes consistent. While the map is inconsistent, for example between a settings write and the matching check-word write, `cfgOut` keeps its old value.
- R8: While `parityErr` is set, `cfgOut` is frozen. Bus writes and reads still work on the stored registers.
- R9: A mismatch that the host repairs before the grace window ends does not set `parityErr`.
- R10: With no bus activity, `cfgOut` and `parityErr` keep their values indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address (settings, then check word, then unmapped) |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, registered |
| cfgOut | output | NUM_REGS*DATA_W | Consistent settings snapshot for protection logic |
| parityErr | output | 1 | Sticky column-parity error flag |

## Verification
The hardest case to reach is the exact edge of the grace window. The flag must stay low through the GRACE-th edge after a write and rise on the next one, and a second settings write partway through the window must push that edge back. The bench creates a mismatch on purpose, waits a counted number of idle cycles, and inserts a restart write at a known offset. It then samples the flag on both sides of the expected edge. After that it repairs the parity to show that the flag and the frozen snapshot both persist, while readback shows the new stored values.

// File: rtl/cfgmap_pkg.sv
package cfgmap_pkg;

  // Strobes issued by control towards the datapath.
  typedef struct packed {
    logic wrReg;     // write one settings register
    logic wrPar;     // write the check word
    logic rdTake;    // capture read data
    logic snapTake;  // copy registers into the protection snapshot
  } cfgStrobes_t;

endpackage

// File: rtl/cfgmap_ctrl.sv
module cfgmap_ctrl
  import cfgmap_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4,
  parameter int GRACE    = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              mismatch,
  output cfgStrobes_t       strobes,
  output logic              parityErr
);

  localparam int CNT_W = $clog2(GRACE + 1);
  localparam logic [ADDR_W-1:0] PAR_ADDR = ADDR_W'(NUM_REGS);
  localparam logic [CNT_W-1:0]  GRACE_C  = CNT_W'(GRACE);

  logic             isReg;
  logic             isPar;
  logic             anyWr;
  logic             graceOver;
  logic [CNT_W-1:0] graceCnt;
  logic             errQ;

  // Address decode and strobe generation
  always_comb begin
    isReg            = (addr < PAR_ADDR);
    isPar            = (addr == PAR_ADDR);
    strobes.wrReg    = wrEn && isReg;
    strobes.wrPar    = wrEn && isPar;
    strobes.rdTake   = rdEn;
    strobes.snapTake = !mismatch && !errQ;
    anyWr            = (wrEn && isReg) || (wrEn && isPar);
    graceOver        = mismatch && !anyWr && (graceCnt == GRACE_C);
  end

  // Grace window: counts mismatching cycles since the last mapped write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      graceCnt <= '0;
    end else if (anyWr) begin
      graceCnt <= '0;
    end else if (mismatch) begin
      if (graceCnt != GRACE_C) graceCnt <= graceCnt + 1'b1;
    end else begin
      graceCnt <= '0;
    end
  end

  // Sticky error flag, cleared only by reset
  always_ff @(posedge clk) begin
    if (!rstN)          errQ <= 1'b0;
    else if (graceOver) errQ <= 1'b1;
  end

  assign parityErr = errQ;

endmodule

// File: rtl/cfgmap_dpath.sv
module cfgmap_dpath
  import cfgmap_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  cfgStrobes_t                  strobes,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wrData,
  output logic                         mismatch,
  output logic [DATA_W-1:0]            rdData,
  output logic [NUM_REGS*DATA_W-1:0]   cfgOut,
  output logic [NUM_REGS*DATA_W-1:0]   regsFlat,
  output logic [DATA_W-1:0]            parWord
);

  localparam logic [ADDR_W-1:0] PAR_ADDR = ADDR_W'(NUM_REGS);

  logic [DATA_W-1:0]          regArr [NUM_REGS];
  logic [NUM_REGS-1:0]        wrHit;
  logic [DATA_W-1:0]          parQ;
  logic [DATA_W-1:0]          colPar;
  logic [DATA_W-1:0]          rdNext;
  logic [DATA_W-1:0]          rdQ;
  logic [NUM_REGS*DATA_W-1:0] snapQ;

  // Per-register write decode and flat view
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    assign wrHit[gi] = strobes.wrReg && (addr == ADDR_W'(gi));
    assign regsFlat[gi*DATA_W +: DATA_W] = regArr[gi];
  end

  // Settings storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regArr[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wrHit[i]) regArr[i] <= wrData;
    end
  end

  // Check word storage
  always_ff @(posedge clk) begin
    if (!rstN)              parQ <= '0;
    else if (strobes.wrPar) parQ <= wrData;
  end

  // Column parity across all settings registers
  always_comb begin
    colPar = '0;
    for (int i = 0; i < NUM_REGS; i++) colPar = colPar ^ regArr[i];
    mismatch = (colPar != parQ);
  end

  // Read multiplexer; unmapped locations give zero
  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rdNext = regArr[i];
    if (addr == PAR_ADDR) rdNext = parQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdQ <= '0;
    else if (strobes.rdTake) rdQ <= rdNext;
  end

  // Consistent snapshot towards protection logic
  always_ff @(posedge clk) begin
    if (!rstN)                 snapQ <= '0;
    else if (strobes.snapTake) snapQ <= regsFlat;
  end

  assign rdData  = rdQ;
  assign cfgOut  = snapQ;
  assign parWord = parQ;

endmodule

// File: rtl/cfg_parity_map.sv
module cfg_parity_map
  import cfgmap_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4,
  parameter int GRACE    = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] cfgOut,
  output logic                       parityErr
);

  cfgStrobes_t                strobes;
  logic                       mismatch;
  logic [NUM_REGS*DATA_W-1:0] regsFlat;
  logic [DATA_W-1:0]          parWord;

  cfgmap_ctrl #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .GRACE(GRACE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .mismatch(mismatch), .strobes(strobes), .parityErr(parityErr)
  );

  cfgmap_dpath #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .addr(addr), .wrData(wrData),
    .mismatch(mismatch), .rdData(rdData), .cfgOut(cfgOut),
    .regsFlat(regsFlat), .parWord(parWord)
  );

endmodule

// File: rtl/cfgmap_checker.sv
module cfgmap_checker #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic                       rdEn,
  input logic [ADDR_W-1:0]          addr,
  input logic [DATA_W-1:0]          rdData,
  input logic [NUM_REGS*DATA_W-1:0] cfgOut,
  input logic                       parityErr,
  input logic                       mismatch,
  input logic [NUM_REGS*DATA_W-1:0] regsFlat,
  input logic [DATA_W-1:0]          parWord
);

  localparam logic [ADDR_W-1:0] PAR_ADDR = ADDR_W'(NUM_REGS);

  // R3: unmapped writes leave storage untouched
  a_r3_unmapped_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr > PAR_ADDR) |=> ($stable(regsFlat) && $stable(parWord)));

  // R3: unmapped reads return zero
  a_r3_unmapped_read: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr > PAR_ADDR) |=> (rdData == '0));

  // R5: the flag only rises out of an inconsistent map
  a_r5_rise_on_mismatch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $past(mismatch));

  // R5: a mapped write never lets the flag rise on the next edge
  a_r5_write_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr <= PAR_ADDR) |=> !$rose(parityErr));

  // R6: sticky flag
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> parityErr);

  // R7: output changes only after a consistent cycle
  a_r7_consistent_update: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut) |-> $past(!mismatch));

  // R8: frozen output while flagged
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> $stable(cfgOut));

endmodule

bind cfg_parity_map cfgmap_checker #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .rdData(rdData), .cfgOut(cfgOut), .parityErr(parityErr),
  .mismatch(mismatch), .regsFlat(regsFlat), .parWord(parWord)
);

// File: tb/sim_cfg_parity_map.sv
`timescale 1ns/1ps
module sim_cfg_parity_map;

  localparam int DW = 8;
  localparam int NR = 4;
  localparam int AW = 3;
  localparam int GR = 5;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic            rdEn = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wrData = '0;
  logic [DW-1:0]   rdData;
  logic [NR*DW-1:0] cfgOut;
  logic            parityErr;

  int nChecks = 0;
  int nErrors = 0;
  logic [DW-1:0] mdl [NR];
  logic [DW-1:0] snap [NR];
  logic [DW-1:0] mpar;

  always #2 clk = ~clk;

  cfg_parity_map #(.DATA_W(DW), .NUM_REGS(NR), .ADDR_W(AW), .GRACE(GR)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .cfgOut(cfgOut), .parityErr(parityErr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  function automatic logic [DW-1:0] xorAll();
    logic [DW-1:0] x = '0;
    for (int i = 0; i < NR; i++) x ^= mdl[i];
    return x;
  endfunction

  task automatic checkOut(input string req);
    for (int i = 0; i < NR; i++) check(req, 32'(cfgOut[i*DW +: DW]), 32'(snap[i]));
  endtask

  task automatic checkReadAll(input string req);
    logic [DW-1:0] d;
    for (int i = 0; i < NR; i++) begin
      rd(AW'(i), d); check(req, 32'(d), 32'(mdl[i]));
    end
    rd(AW'(NR), d); check(req, 32'(d), 32'(mpar));
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    for (int i = 0; i < NR; i++) begin mdl[i] = '0; snap[i] = '0; end
    mpar = '0;
    idle(1);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    nErrors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin : stim
    logic [DW-1:0] d;
    logic [DW-1:0] v;
    doReset();

    // R1: reset state
    check("R1 err", 32'(parityErr), 0);
    checkOut("R1 cfgOut");
    checkReadAll("R1 readback");

    // R2, R4, R7: sweep settings and check-word updates
    for (int i = 0; i < NR; i++) begin
      for (int k = 0; k < 3; k++) begin
        v = DW'(k * 37 + i * 11 + 1);
        wr(AW'(i), v);
        mdl[i] = v;
        checkOut("R7 hold during mismatch");
        mpar = xorAll();
        wr(AW'(NR), mpar);
        checkOut("R7 one-edge latency");
        idle(1);
        for (int j = 0; j < NR; j++) snap[j] = mdl[j];
        checkOut("R7 update after consistent");
        rd(AW'(i), d);  check("R2 reg readback", 32'(d), 32'(v));
        rd(AW'(NR), d); check("R2 check word readback", 32'(d), 32'(mpar));
        check("R4 consistent no err", 32'(parityErr), 0);
      end
    end

    // R3: unmapped accesses
    for (int a = NR + 1; a < (1 << AW); a++) begin
      wr(AW'(a), 8'hA5);
      rd(AW'(a), d);
      check("R3 unmapped read zero", 32'(d), 0);
    end
    checkReadAll("R3 storage untouched");
    checkOut("R3 output untouched");
    check("R3 no err", 32'(parityErr), 0);

    // R10: host silent
    idle(100);
    checkOut("R10 output persists");
    check("R10 err persists", 32'(parityErr), 0);

    // R9: mismatch repaired inside the window
    wr(0, mdl[0] ^ 8'h01);
    mdl[0] = mdl[0] ^ 8'h01;
    idle(GR - 1);
    check("R9 inside window", 32'(parityErr), 0);
    mpar = xorAll();
    wr(AW'(NR), mpar);
    idle(GR + 3);
    check("R9 repaired no err", 32'(parityErr), 0);
    for (int j = 0; j < NR; j++) snap[j] = mdl[j];
    checkOut("R9 output follows repair");

    // R5: window restart and exact error edge
    wr(1, mdl[1] ^ 8'h10);
    mdl[1] = mdl[1] ^ 8'h10;
    idle(GR - 2);
    wr(2, mdl[2] ^ 8'h20);
    mdl[2] = mdl[2] ^ 8'h20;
    idle(GR);
    check("R5 no err at GRACE edges", 32'(parityErr), 0);
    idle(1);
    check("R5 err at GRACE+1 edges", 32'(parityErr), 1);
    checkOut("R8 output frozen at error");

    // R6 / R8: repair does not clear the flag or unfreeze the output
    mpar = xorAll();
    wr(AW'(NR), mpar);
    idle(10);
    check("R6 sticky after repair", 32'(parityErr), 1);
    checkOut("R8 output frozen after repair");
    wr(3, 8'h3C);
    mdl[3] = 8'h3C;
    checkReadAll("R8 bus still works");
    checkOut("R8 output frozen after write");

    // R1: reset clears the flag again
    doReset();
    check("R1 err after reset", 32'(parityErr), 0);
    checkOut("R1 cfgOut after reset");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule